// File: doc/BRIEF.md
# Multi-Processor Bus Type Decoder

This block sits at the front of a local-bus slave that is shared by several embedded processor families. A two-bit bus-type input tells it which kind of master runs the current cycle. When a cycle starts, the block samples that input and keeps the decoded mode until the next cycle starts. The mode sets the data-path width, the byte lanes whose enables count, and the bit pattern that marks the boot region. It also captures the address from a multiplexed address/data bus, so 16-bit and 32-bit masters can share the same pins.

A cycle normally starts on the rising edge of the address-latch-enable input. Only in type 01 can an active-low address strobe also start a cycle. Either source may be left idle: the strobe can be tied high and the latch enable can stay low. The address latch is transparent, on every clock, while the latch enable is high, and it holds its value after the enable falls. In 32-bit modes the upper sixteen address bits come from the multiplexed upper bus. In 16-bit mode they are passed straight through from the dedicated high-address pins. Outputs go to the cycle-control and register logic behind the block. That logic is outside this design.

Top module: `bus_type_front`

## Requirements
- R1: After synchronous active-high reset, cyc_start_o=0, cyc_active_o=0, addr_o[15:0]=0 and the mode is type 00 (wide_o=0, lane_mask_o=4'b0011).
- R2: A clock edge that sees ale_i high after it was low on the previous edge starts a cycle, and cyc_start_o is high for exactly the following clock cycle.
- R3: A clock edge that sees ads_n_i low after it was high starts a cycle only when btype_i=2'b01. With any other type, the strobe changes neither cyc_start_o, the mode nor addr_o.
- R4: btype_i is sampled only at a cycle start. Changes at any other time leave wide_o and lane_mask_o unchanged.
- R5: The mode sets the outputs as follows: type 00 gives wide_o=0 and lane_mask_o=4'b0011; types 01 and 10 give wide_o=1 and lane_mask_o=4'b1111; type 11 gives wide_o=1 and lane_mask_o=4'b1001 (bit n is the lane of byte enable n).
- R6: boot_hit_o=1 exactly when {addr_o[31],addr_o[26:24]} equals 4'b0000 in type 00, 4'b1111 in type 01, or 4'b1110 in types 10 and 11.
- R7: On every clock edge where ale_i is high or a cycle starts, addr_o[15:0] takes ad_i. At all other times it holds its value.
- R8: In types 01, 10 and 11, addr_o[31:16] is captured from ad_hi_i on the same edges as R7 and held otherwise. In type 00, addr_o[31:16] follows a_hi_i combinationally.
- R9: cyc_active_o goes to 1 on a cycle start and to 0 on an edge with cyc_done_i high. If both happen on the same edge, the start wins.
- R10: Asserting reset in the middle of a cycle restores the R1 state on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btype_i | input | 2 | Bus-type code of the current master |
| ale_i | input | 1 | Address latch enable, active high |
| ads_n_i | input | 1 | Address strobe, active low (used only in type 01) |
| ad_i | input | 16 | Low multiplexed address/data lines |
| ad_hi_i | input | 16 | Upper multiplexed address/data lines (32-bit masters) |
| a_hi_i | input | 16 | Dedicated high-address inputs (16-bit master) |
| cyc_done_i | input | 1 | Cycle termination from downstream logic |
| cyc_start_o | output | 1 | One-cycle cycle-start strobe |
| cyc_active_o | output | 1 | A cycle is in progress |
| addr_o | output | 32 | Latched address |
| wide_o | output | 1 | 1 = 32-bit data path, 0 = 16-bit |
| lane_mask_o | output | 4 | Byte enables that are valid in this mode |
| boot_hit_o | output | 1 | Address lies in the mode's boot region |

## Verification
The assertions assume that reset is held for at least one edge before any bus activity. They also assume that the inputs are stable around each sampling edge, so that the edge detectors see clean levels. The bench drives every input on the falling clock edge and checks on the next falling edge. It always lets ale_i go low again between cycles and holds the strobe high except in the strobe tests. The exhaustive sweep over the four types and sixteen boot-tap values puts deliberately conflicting values on the unused high-address source. This shows that the wrong source never reaches addr_o.

// File: rtl/bt_pkg.sv
package bt_pkg;

  typedef enum logic [1:0] {
    BT_NARROW = 2'b00,
    BT_WIDE_A = 2'b01,
    BT_WIDE_B = 2'b10,
    BT_SPLIT  = 2'b11
  } bt_mode_e;

  // Data path width flag for a mode.
  function automatic logic bt_is_wide(input bt_mode_e m);
    return (m != BT_NARROW);
  endfunction

  // Byte lanes whose enables are meaningful; bit n = byte enable n.
  function automatic logic [3:0] bt_lane_mask(input bt_mode_e m);
    logic [3:0] r;
    unique case (m)
      BT_NARROW: r = 4'b0011;
      BT_WIDE_A: r = 4'b1111;
      BT_WIDE_B: r = 4'b1111;
      default:   r = 4'b1001;
    endcase
    return r;
  endfunction

  // Expected value of the four boot tap bits for a mode.
  function automatic logic [3:0] bt_boot_pat(input bt_mode_e m);
    logic [3:0] r;
    unique case (m)
      BT_NARROW: r = 4'b0000;
      BT_WIDE_A: r = 4'b1111;
      default:   r = 4'b1110;
    endcase
    return r;
  endfunction

  // Boot tap bits: top bit followed by the three bits below the nibble boundary.
  function automatic logic [3:0] bt_boot_tap(input logic [31:0] a);
    return {a[31], a[26:24]};
  endfunction

endpackage

// File: rtl/bt_start_detect.sv
module bt_start_detect
  import bt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] btype_i,
  input  logic       ale_i,
  input  logic       ads_n_i,
  output logic       ale_rise_o,
  output logic       ads_fall_o,
  output logic       start_o
);
  logic ale_q;
  logic ads_n_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ale_q   <= 1'b0;
      ads_n_q <= 1'b1;
    end else begin
      ale_q   <= ale_i;
      ads_n_q <= ads_n_i;
    end
  end

  assign ale_rise_o = ale_i & ~ale_q;
  assign ads_fall_o = ~ads_n_i & ads_n_q;
  // Strobe-initiated cycles are honoured only for the type that may lack a latch enable.
  assign start_o = ale_rise_o | (ads_fall_o & (bt_mode_e'(btype_i) == BT_WIDE_A));
endmodule

// File: rtl/bt_mode_track.sv
module bt_mode_track
  import bt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       done_i,
  input  logic [1:0] btype_i,
  output bt_mode_e   mode_o,
  output bt_mode_e   eff_mode_o,
  output logic       active_o,
  output logic       start_q_o
);
  bt_mode_e mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= BT_NARROW;
      active_o  <= 1'b0;
      start_q_o <= 1'b0;
    end else begin
      start_q_o <= start_i;
      if (start_i) begin
        mode_q   <= bt_mode_e'(btype_i);
        active_o <= 1'b1;
      end else if (done_i) begin
        active_o <= 1'b0;
      end
    end
  end

  assign mode_o     = mode_q;
  // Mode in force for a capture happening on this edge.
  assign eff_mode_o = start_i ? bt_mode_e'(btype_i) : mode_q;
endmodule

// File: rtl/bt_addr_latch.sv
module bt_addr_latch #(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture_i,
  input  logic              wide_cap_i,
  input  logic              wide_now_i,
  input  logic [HALF_W-1:0] ad_lo_i,
  input  logic [HALF_W-1:0] ad_hi_i,
  input  logic [HALF_W-1:0] a_direct_i,
  output logic [2*HALF_W-1:0] addr_o
);
  localparam int ADDR_W = 2 * HALF_W;

  logic [HALF_W-1:0] lo_q;
  logic [HALF_W-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (capture_i) begin
      lo_q <= ad_lo_i;
      if (wide_cap_i) hi_q <= ad_hi_i;
    end
  end

  logic [ADDR_W-1:0] joined;
  assign joined = {(wide_now_i ? hi_q : a_direct_i), lo_q};
  assign addr_o = joined;
endmodule

// File: rtl/bt_lane_decode.sv
module bt_lane_decode
  import bt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LANES  = 4
) (
  input  bt_mode_e          mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              wide_o,
  output logic [LANES-1:0]  lane_mask_o,
  output logic              boot_hit_o
);
  logic [3:0] tap;
  logic [3:0] pat;
  logic [3:0] full_mask;

  assign tap       = bt_boot_tap(addr_i);
  assign pat       = bt_boot_pat(mode_i);
  assign full_mask = bt_lane_mask(mode_i);

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign lane_mask_o[i] = full_mask[i];
    end
  endgenerate

  assign wide_o     = bt_is_wide(mode_i);
  assign boot_hit_o = (tap == pat);
endmodule

// File: rtl/bus_type_front.sv
module bus_type_front
  import bt_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int LANES  = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           btype_i,
  input  logic                 ale_i,
  input  logic                 ads_n_i,
  input  logic [HALF_W-1:0]    ad_i,
  input  logic [HALF_W-1:0]    ad_hi_i,
  input  logic [HALF_W-1:0]    a_hi_i,
  input  logic                 cyc_done_i,
  output logic                 cyc_start_o,
  output logic                 cyc_active_o,
  output logic [2*HALF_W-1:0]  addr_o,
  output logic                 wide_o,
  output logic [LANES-1:0]     lane_mask_o,
  output logic                 boot_hit_o
);
  localparam int ADDR_W = 2 * HALF_W;

  // Named internal events, brought out for the checker.
  logic     ale_rise;
  logic     ads_fall;
  logic     start_evt;
  logic     capture;
  bt_mode_e mode_q;
  bt_mode_e eff_mode;

  bt_start_detect u_det (
    .clk       (clk),
    .rst       (rst),
    .btype_i   (btype_i),
    .ale_i     (ale_i),
    .ads_n_i   (ads_n_i),
    .ale_rise_o(ale_rise),
    .ads_fall_o(ads_fall),
    .start_o   (start_evt)
  );

  bt_mode_track u_mode (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_evt),
    .done_i    (cyc_done_i),
    .btype_i   (btype_i),
    .mode_o    (mode_q),
    .eff_mode_o(eff_mode),
    .active_o  (cyc_active_o),
    .start_q_o (cyc_start_o)
  );

  assign capture = ale_i | start_evt;

  bt_addr_latch #(.HALF_W(HALF_W)) u_addr (
    .clk       (clk),
    .rst       (rst),
    .capture_i (capture),
    .wide_cap_i(bt_is_wide(eff_mode)),
    .wide_now_i(bt_is_wide(mode_q)),
    .ad_lo_i   (ad_i),
    .ad_hi_i   (ad_hi_i),
    .a_direct_i(a_hi_i),
    .addr_o    (addr_o)
  );

  bt_lane_decode #(.ADDR_W(ADDR_W), .LANES(LANES)) u_dec (
    .mode_i     (mode_q),
    .addr_i     (addr_o),
    .wide_o     (wide_o),
    .lane_mask_o(lane_mask_o),
    .boot_hit_o (boot_hit_o)
  );
endmodule

// File: rtl/bt_check.sv
module bt_check (
  input logic        clk,
  input logic        rst,
  input logic [1:0]  btype_i,
  input logic        ale_i,
  input logic        cyc_done_i,
  input logic        cyc_start_o,
  input logic        cyc_active_o,
  input logic [31:0] addr_o,
  input logic        wide_o,
  input logic [3:0]  lane_mask_o,
  input logic        ale_rise,
  input logic        ads_fall,
  input logic        start_evt
);
  // R2: a detected start gives a strobe on the next cycle
  a_r2_start_strobe: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> cyc_start_o);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !start_evt |=> !cyc_start_o);
  // R3: strobe outside type 01 starts nothing
  a_r3_strobe_ignored: assert property (@(posedge clk) disable iff (rst)
    (ads_fall && btype_i != 2'b01 && !ale_rise) |=> !cyc_start_o);
  // R4: mode-dependent outputs hold between starts
  a_r4_mode_hold: assert property (@(posedge clk) disable iff (rst)
    !start_evt |=> ($stable(lane_mask_o) && $stable(wide_o)));
  // R5: lane mask consistent with width
  a_r5_narrow_lanes: assert property (@(posedge clk) disable iff (rst)
    !wide_o |-> lane_mask_o == 4'b0011);
  a_r5_wide_lanes: assert property (@(posedge clk) disable iff (rst)
    wide_o |-> (lane_mask_o[3] && lane_mask_o[0]));
  // R7: low address holds when nothing captures
  a_r7_lo_hold: assert property (@(posedge clk) disable iff (rst)
    (!ale_i && !start_evt) |=> $stable(addr_o[15:0]));
  // R9: active flag set by start, cleared by done
  a_r9_active_set: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> cyc_active_o);
  a_r9_active_clr: assert property (@(posedge clk) disable iff (rst)
    (cyc_done_i && !start_evt) |=> !cyc_active_o);
endmodule

bind bus_type_front bt_check u_chk (
  .clk         (clk),
  .rst         (rst),
  .btype_i     (btype_i),
  .ale_i       (ale_i),
  .cyc_done_i  (cyc_done_i),
  .cyc_start_o (cyc_start_o),
  .cyc_active_o(cyc_active_o),
  .addr_o      (addr_o),
  .wide_o      (wide_o),
  .lane_mask_o (lane_mask_o),
  .ale_rise    (ale_rise),
  .ads_fall    (ads_fall),
  .start_evt   (start_evt)
);

// File: tb/tb_bus_type_front.sv
module tb_bus_type_front;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  btype_i;
  logic        ale_i;
  logic        ads_n_i;
  logic [15:0] ad_i;
  logic [15:0] ad_hi_i;
  logic [15:0] a_hi_i;
  logic        cyc_done_i;
  logic        cyc_start_o;
  logic        cyc_active_o;
  logic [31:0] addr_o;
  logic        wide_o;
  logic [3:0]  lane_mask_o;
  logic        boot_hit_o;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  bus_type_front dut (
    .clk(clk), .rst(rst), .btype_i(btype_i), .ale_i(ale_i), .ads_n_i(ads_n_i),
    .ad_i(ad_i), .ad_hi_i(ad_hi_i), .a_hi_i(a_hi_i), .cyc_done_i(cyc_done_i),
    .cyc_start_o(cyc_start_o), .cyc_active_o(cyc_active_o), .addr_o(addr_o),
    .wide_o(wide_o), .lane_mask_o(lane_mask_o), .boot_hit_o(boot_hit_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_lanes(input int bt);
    if (bt == 0) return 4'd3;
    if (bt == 3) return 4'd9;
    return 4'd15;
  endfunction

  function automatic logic [3:0] exp_pat(input int bt);
    if (bt == 0) return 4'd0;
    if (bt == 1) return 4'd15;
    return 4'd14;
  endfunction

  // Place four boot tap bits at positions 15 and 10:8 of an upper half.
  function automatic logic [15:0] put_tap(input logic [15:0] base, input logic [3:0] t);
    return (base & 16'h78FF) | {t[3], 4'b0000, t[2:0], 8'h00};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1; btype_i = 0; ale_i = 0; ads_n_i = 1; ad_i = 16'h1234;
    ad_hi_i = 16'hABCD; a_hi_i = 16'h0F0F; cyc_done_i = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 start", {31'd0, cyc_start_o}, 0);
    check("R1 active", {31'd0, cyc_active_o}, 0);
    check("R1 addr lo", {16'd0, addr_o[15:0]}, 0);
    check("R1 wide", {31'd0, wide_o}, 0);
    check("R1 lanes", {28'd0, lane_mask_o}, 32'd3);
    check("R8 passthrough hi", {16'd0, addr_o[31:16]}, 32'h0F0F);

    // Exhaustive sweep: type x boot tap value
    for (int bt = 0; bt < 4; bt++) begin
      for (int t = 0; t < 16; t++) begin
        logic [15:0] lo, hw, hd, exp_hi;
        lo = 16'(t * 16'h0911 + bt * 16'h3001 + 16'h0101);
        hw = put_tap(16'h5A5A, (bt == 0) ? ~4'(t) : 4'(t));
        hd = put_tap(16'hC3C3, (bt == 0) ? 4'(t) : ~4'(t));
        exp_hi = (bt == 0) ? hd : hw;
        @(negedge clk);
        btype_i = 2'(bt); ale_i = 1; ad_i = lo; ad_hi_i = hw; a_hi_i = hd;
        @(negedge clk);
        check("R2 strobe", {31'd0, cyc_start_o}, 1);
        check("R7 lo captured", {16'd0, addr_o[15:0]}, {16'd0, lo});
        check("R8 hi source", {16'd0, addr_o[31:16]}, {16'd0, exp_hi});
        check("R5 wide", {31'd0, wide_o}, (bt != 0) ? 1 : 0);
        check("R5 lanes", {28'd0, lane_mask_o}, {28'd0, exp_lanes(bt)});
        check("R6 boot", {31'd0, boot_hit_o}, (4'(t) == exp_pat(bt)) ? 1 : 0);
        check("R9 active set", {31'd0, cyc_active_o}, 1);
        ale_i = 0; ad_i = ~lo; ad_hi_i = ~hw; btype_i = 2'(bt ^ 3);
        if (bt == 0) a_hi_i = ~hd;
        @(negedge clk);
        check("R2 single pulse", {31'd0, cyc_start_o}, 0);
        check("R7 lo held", {16'd0, addr_o[15:0]}, {16'd0, lo});
        check("R4 lanes held", {28'd0, lane_mask_o}, {28'd0, exp_lanes(bt)});
        check("R8 hi after ALE", {16'd0, addr_o[31:16]}, {16'd0, (bt == 0) ? ~hd : hw});
        cyc_done_i = 1;
        @(negedge clk);
        cyc_done_i = 0;
        check("R9 active clr", {31'd0, cyc_active_o}, 0);
      end
    end

    // Transparency while ALE stays high; type change mid-cycle ignored
    @(negedge clk);
    btype_i = 2'b11; ale_i = 1; ad_i = 16'h1111; ad_hi_i = 16'h2222;
    @(negedge clk);
    btype_i = 2'b00; ad_i = 16'h3333; ad_hi_i = 16'h4444;
    @(negedge clk);
    check("R7 transparent", {16'd0, addr_o[15:0]}, 32'h3333);
    check("R8 transparent hi", {16'd0, addr_o[31:16]}, 32'h4444);
    check("R4 mode held", {28'd0, lane_mask_o}, 32'd9);
    ale_i = 0;

    // Strobe start in type 01
    @(negedge clk);
    btype_i = 2'b01; ads_n_i = 0; ad_i = 16'h5678; ad_hi_i = 16'h8F00;
    @(negedge clk);
    check("R3 strobe start", {31'd0, cyc_start_o}, 1);
    check("R3 strobe addr", addr_o, 32'h8F005678);
    check("R3 strobe lanes", {28'd0, lane_mask_o}, 32'd15);
    check("R6 type01 boot", {31'd0, boot_hit_o}, 1);
    ads_n_i = 1;
    @(negedge clk);
    // Strobe in type 11 must be ignored
    btype_i = 2'b11; ads_n_i = 0; ad_i = 16'h9999; ad_hi_i = 16'h7777;
    @(negedge clk);
    check("R3 strobe ignored", {31'd0, cyc_start_o}, 0);
    check("R3 mode kept", {28'd0, lane_mask_o}, 32'd15);
    check("R3 addr kept", addr_o, 32'h8F005678);
    ads_n_i = 1;

    // Start and done on same edge
    @(negedge clk);
    cyc_done_i = 1; @(negedge clk); cyc_done_i = 0;
    btype_i = 2'b10; ale_i = 1; cyc_done_i = 1; ad_i = 16'hAAAA; ad_hi_i = 16'hBBBB;
    @(negedge clk);
    cyc_done_i = 0;
    check("R9 start wins", {31'd0, cyc_active_o}, 1);
    ale_i = 0;

    // Reset mid-cycle
    @(negedge clk);
    rst = 1; a_hi_i = 16'h0123;
    @(negedge clk);
    rst = 0;
    check("R10 active", {31'd0, cyc_active_o}, 0);
    check("R10 addr", addr_o, 32'h01230000);
    check("R10 lanes", {28'd0, lane_mask_o}, 32'd3);
    check("R10 start", {31'd0, cyc_start_o}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule